// File: doc/BRIEF.md
# Virtual Lane Alignment and Reorder

This block sits behind four word-locked receive lanes of a multi-lane link. The physical lanes can be wired or routed in any permutation, so the word stream found on physical lane 2 may really belong to logical lane 0. Every lane carries an in-band tag word at a fixed spacing. The tag names the logical (virtual) lane that the stream belongs to. The block finds these tags and builds lock on each lane with hysteresis. It learns which physical lane feeds which virtual lane, then steers every stream to its logical output position.

Tag words are removed from the output. Nothing is forwarded until all four lanes are tag-locked and their lane numbers form a clean permutation. Two cases count as a catastrophic error: two locked lanes claiming the same lane number, or the aligned state collapsing. In either case the whole mapping is thrown away and acquisition starts again without outside help. The tag spacing and both hysteresis thresholds are parameters. The defaults are a spacing of 16384 words, 2 matching tags to lock and 4 consecutive failures to unlock.

Top module: `vlane_align`

## Requirements
- R1: While reset is held and right after it, am_lock, full_lock, aligned and out_valid are all zero.
- R2: A tag word has sync header 2'b10 in bits [65:64], the constant 56'hC35A963CA5690F in bits [63:8], and a virtual lane number below 4 in bits [7:0]. Every other word is data.
- R3: A lane gains am_lock on the tag that completes two consecutive tags with the same lane number, spaced exactly PERIOD valid words apart (16 in the bench). A single tag never locks.
- R4: A locked lane checks the word in each expected tag position. A non-tag, or a tag with a different lane number, is one failure. The fourth consecutive failure clears am_lock, and a correct tag resets the failure count.
- R5: lane_map field p (2 bits at [2p+1:2p]) gives the virtual lane learned on physical lane p. full_lock[p] is am_lock[p] AND in_wlock[p]. Deasserting in_wlock[p] clears am_lock[p] on the next edge.
- R6: aligned is high exactly when all four lanes hold am_lock and their lane numbers are all different.
- R7: If two locked lanes hold the same lane number, or aligned falls, every lane drops its lock on the next edge. The lanes then reacquire from the tags that follow.
- R8: One cycle after a valid input word is taken while aligned, out_word field v (66 bits at [66v+65:66v]) carries the word from the physical lane mapped to v, with out_valid[v] high. While aligned is low, out_valid stays zero.
- R9: While a lane is locked, the word in its tag position is removed: the matching out_valid bit is low for that cycle.
- R10: Cycles with in_valid low neither advance the tag spacing count nor change lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 264 | Four 66-bit physical lane words, lane p at [66p+65:66p] |
| in_valid | input | 4 | Word valid per physical lane |
| in_wlock | input | 4 | Word-boundary lock per physical lane |
| out_word | output | 264 | Four 66-bit words in virtual lane order |
| out_valid | output | 4 | Valid per virtual output lane |
| am_lock | output | 4 | Tag lock per physical lane |
| full_lock | output | 4 | Word lock and tag lock together, per physical lane |
| aligned | output | 1 | All lanes locked with a valid permutation |
| lane_map | output | 8 | Learned virtual lane number per physical lane |

## Verification
Two things can happen in the same cycle. The tag that completes acquisition is itself removed from the output, and in that same cycle aligned rises, so the first forwarded word is the data word that follows the tag. The bench provokes this at each lock-up, with idle gaps inserted at random. It expects out_valid low for the tag cycle and high with the correct steered word one cycle after the next data word. The other collision is a lock loss that coincides with live forwarding. The bench withholds tags on one lane and expects that lane to unlock on the fourth missed tag, and every lane to drop lock on the following edge.

// File: rtl/vlane_pkg.sv
`timescale 1ns/1ps
package vlane_pkg;
  localparam int WW = 66;
  localparam logic [1:0]  CTRL_HDR = 2'b10;
  localparam logic [55:0] TAG_BODY = 56'hC35A963CA5690F;

  // A word is a tag when its header and body match and its lane field is in range.
  function automatic logic is_tag(input logic [WW-1:0] w, input int unsigned nl);
    return (w[65:64] == CTRL_HDR) && (w[63:8] == TAG_BODY) && (32'(w[7:0]) < nl);
  endfunction

  function automatic logic [7:0] tag_lane(input logic [WW-1:0] w);
    return w[7:0];
  endfunction
endpackage

// File: rtl/vlane_track.sv
`timescale 1ns/1ps
module vlane_track #(
  parameter int NL     = 4,
  parameter int LW     = 2,
  parameter int PERIOD = 16384,
  parameter int ACQ    = 2,
  parameter int LOSS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [vlane_pkg::WW-1:0] word,
  input  logic                 valid,
  input  logic                 wlock,
  output logic                 locked,
  output logic [LW-1:0]        lane_id,
  output logic                 drop
);
  localparam int CW = $clog2(PERIOD);
  localparam int HW = $clog2(ACQ + 1);
  localparam int MW = $clog2(LOSS + 1);

  logic [CW-1:0] cnt;
  logic [HW-1:0] hits;
  logic [MW-1:0] misses;
  logic          tag_seen, slot, id_match;
  logic [7:0]    tag_num;

  assign tag_seen = valid && vlane_pkg::is_tag(word, NL);
  assign tag_num  = vlane_pkg::tag_lane(word);
  assign id_match = (tag_num[LW-1:0] == lane_id);
  assign slot     = (cnt == CW'(PERIOD - 1));
  assign drop     = valid && locked && slot;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || !wlock) begin
      locked  <= 1'b0;
      lane_id <= '0;
      cnt     <= '0;
      hits    <= '0;
      misses  <= '0;
    end else if (valid) begin
      if (locked) begin
        if (slot) begin
          cnt <= '0;
          if (tag_seen && id_match) begin
            misses <= '0;
          end else if (misses == MW'(LOSS - 1)) begin
            locked <= 1'b0;
            hits   <= '0;
            misses <= '0;
          end else begin
            misses <= misses + MW'(1);
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (tag_seen) begin
        cnt <= '0;
        if (hits != '0 && id_match && slot) begin
          if (hits == HW'(ACQ - 1)) begin
            locked <= 1'b1;
            misses <= '0;
          end
          hits <= hits + HW'(1);
        end else begin
          lane_id <= tag_num[LW-1:0];
          hits    <= HW'(1);
        end
      end else begin
        cnt <= slot ? '0 : cnt + CW'(1);
        if (slot) hits <= '0;
      end
    end
  end
endmodule

// File: rtl/vlane_xbar.sv
`timescale 1ns/1ps
module vlane_xbar #(
  parameter int NL = 4,
  parameter int LW = 2,
  parameter int WW = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NL*WW-1:0] in_word,
  input  logic [NL-1:0]    in_keep,
  input  logic [NL*LW-1:0] map,
  output logic [NL*WW-1:0] out_word,
  output logic [NL-1:0]    out_valid
);
  for (genvar v = 0; v < NL; v++) begin : g_out
    logic [WW-1:0] sel_word;
    logic          sel_keep;

    always_comb begin
      sel_word = '0;
      sel_keep = 1'b0;
      for (int p = 0; p < NL; p++) begin
        if (map[p*LW +: LW] == LW'(v)) begin
          sel_word = in_word[p*WW +: WW];
          sel_keep = in_keep[p];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid[v]          <= 1'b0;
        out_word[v*WW +: WW]  <= '0;
      end else begin
        out_valid[v]          <= en && sel_keep;
        out_word[v*WW +: WW]  <= sel_word;
      end
    end
  end
endmodule

// File: rtl/vlane_align.sv
`timescale 1ns/1ps
module vlane_align #(
  parameter int NL     = 4,
  parameter int PERIOD = 16384,
  parameter int ACQ    = 2,
  parameter int LOSS   = 4,
  parameter int LW     = $clog2(NL),
  parameter int WW     = vlane_pkg::WW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL*WW-1:0] in_word,
  input  logic [NL-1:0]    in_valid,
  input  logic [NL-1:0]    in_wlock,
  output logic [NL*WW-1:0] out_word,
  output logic [NL-1:0]    out_valid,
  output logic [NL-1:0]    am_lock,
  output logic [NL-1:0]    full_lock,
  output logic             aligned,
  output logic [NL*LW-1:0] lane_map
);
  logic [NL-1:0] drop_w;
  logic [NL-1:0] keep_w;
  logic          dup_w;
  logic          flush_w;
  logic          aligned_q;

  for (genvar p = 0; p < NL; p++) begin : g_lane
    vlane_track #(
      .NL(NL), .LW(LW), .PERIOD(PERIOD), .ACQ(ACQ), .LOSS(LOSS)
    ) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_w),
      .word    (in_word[p*WW +: WW]),
      .valid   (in_valid[p]),
      .wlock   (in_wlock[p]),
      .locked  (am_lock[p]),
      .lane_id (lane_map[p*LW +: LW]),
      .drop    (drop_w[p])
    );
  end

  // Two locked lanes claiming one virtual lane make the mapping unusable.
  always_comb begin
    dup_w = 1'b0;
    for (int i = 0; i < NL; i++) begin
      for (int j = i + 1; j < NL; j++) begin
        if (am_lock[i] && am_lock[j] &&
            lane_map[i*LW +: LW] == lane_map[j*LW +: LW])
          dup_w = 1'b1;
      end
    end
  end

  assign aligned   = (&am_lock) && !dup_w;
  assign flush_w   = dup_w || (aligned_q && !aligned);
  assign full_lock = am_lock & in_wlock;
  assign keep_w    = in_valid & ~drop_w;

  always_ff @(posedge clk) begin
    if (!rst_n) aligned_q <= 1'b0;
    else        aligned_q <= aligned;
  end

  vlane_xbar #(.NL(NL), .LW(LW), .WW(WW)) i_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (aligned),
    .in_word   (in_word),
    .in_keep   (keep_w),
    .map       (lane_map),
    .out_word  (out_word),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/vlane_align_chk.sv
`timescale 1ns/1ps
module vlane_align_chk #(
  parameter int NL = 4,
  parameter int LW = 2,
  parameter int WW = 66
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NL*WW-1:0] in_word,
  input logic [NL-1:0]    in_valid,
  input logic [NL-1:0]    in_wlock,
  input logic [NL-1:0]    out_valid,
  input logic [NL-1:0]    am_lock,
  input logic             aligned,
  input logic [NL*LW-1:0] lane_map,
  input logic             flush_w,
  input logic [NL-1:0]    drop_w
);
  p_quiet_unaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |=> (out_valid == '0));

  p_aligned_all_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> (&am_lock));

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (am_lock == '0));

  for (genvar p = 0; p < NL; p++) begin : g_lane_chk
    p_wlock_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_wlock[p] |=> !am_lock[p]);

    p_lock_on_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(am_lock[p]) |->
        $past(in_valid[p] && vlane_pkg::is_tag(in_word[p*WW +: WW], NL)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid[p] && in_wlock[p] && !flush_w) |=> $stable(am_lock[p]));

    for (genvar v = 0; v < NL; v++) begin : g_drop_chk
      p_tag_removed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_w[p] && lane_map[p*LW +: LW] == LW'(v)) |=> !out_valid[v]);
    end
  end
endmodule

bind vlane_align vlane_align_chk #(.NL(NL), .LW(LW), .WW(WW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_word   (in_word),
  .in_valid  (in_valid),
  .in_wlock  (in_wlock),
  .out_valid (out_valid),
  .am_lock   (am_lock),
  .aligned   (aligned),
  .lane_map  (lane_map),
  .flush_w   (flush_w),
  .drop_w    (drop_w)
);

// File: tb/test_vlane_align.sv
`timescale 1ns/1ps
module test_vlane_align;
  localparam int NL = 4;
  localparam int WW = 66;
  localparam int P  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL*WW-1:0] in_word = '0;
  logic [NL-1:0]    in_valid = '0;
  logic [NL-1:0]    in_wlock = '1;
  logic [NL*WW-1:0] out_word;
  logic [NL-1:0]    out_valid;
  logic [NL-1:0]    am_lock;
  logic [NL-1:0]    full_lock;
  logic             aligned;
  logic [NL*2-1:0]  lane_map;

  always #4 clk = ~clk;

  vlane_align #(.NL(NL), .PERIOD(P), .ACQ(2), .LOSS(4)) i_vlane_align (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_wlock(in_wlock), .out_word(out_word), .out_valid(out_valid),
    .am_lock(am_lock), .full_lock(full_lock), .aligned(aligned),
    .lane_map(lane_map)
  );

  int checks = 0;
  int failures = 0;
  int perm [NL];
  int idf [NL];
  bit bad [NL];
  int t;
  int good;
  bit last_slot;
  bit ever_al;
  logic [WW-1:0] cur [NL];

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk_tag(input int id);
    return {2'b10, 56'hC35A963CA5690F, 8'(id)};
  endfunction

  function automatic logic [WW-1:0] mk_data();
    return {2'b01, 32'($urandom), 32'($urandom)};
  endfunction

  task automatic shuffle();
    for (int i = 0; i < NL; i++) perm[i] = i;
    for (int i = NL - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int tmp = perm[i];
      perm[i] = perm[j];
      perm[j] = tmp;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    in_wlock = '1;
    t = 0; good = 0; ever_al = 0;
    for (int i = 0; i < NL; i++) begin idf[i] = -1; bad[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One bench cycle: drive all lanes, then optionally check the steered output.
  task automatic step(input bit chk, input bit allow_gap);
    bit gap, slot, al_exp, clean;
    @(negedge clk);
    gap = allow_gap && ($urandom % 8 == 0);
    slot = (t % P == 0);
    clean = 1;
    for (int p = 0; p < NL; p++) begin
      if (slot && !bad[p]) cur[p] = mk_tag(idf[p] >= 0 ? idf[p] : perm[p]);
      else cur[p] = mk_data();
      if (bad[p] || idf[p] >= 0) clean = 0;
      in_word[p*WW +: WW] = cur[p];
    end
    in_valid = gap ? '0 : '1;
    al_exp = (good >= 2);
    if (!gap && slot && clean) good++;
    @(posedge clk);
    #1;
    if (chk) begin
      for (int v = 0; v < NL; v++) begin
        int src = 0;
        bit ev;
        for (int p = 0; p < NL; p++) if (perm[p] == v) src = p;
        ev = al_exp && !gap && !slot;
        check(out_valid[v] == ev, "R8/R9/R10 out_valid", 66'(out_valid[v]), 66'(ev));
        if (ev) check(out_word[v*WW +: WW] == cur[src], "R8 steered word",
                      out_word[v*WW +: WW], cur[src]);
      end
    end
    ever_al |= aligned;
    last_slot = !gap && slot;
    if (!gap) t++;
  endtask

  task automatic to_slot();
    do step(0, 0); while (!last_slot);
  endtask

  initial begin
    do_reset();
    shuffle();
    #1;
    check(am_lock == '0 && aligned == 0 && out_valid == '0 && full_lock == '0,
          "R1 reset state", 66'({am_lock, full_lock, aligned, out_valid}), 66'(0));

    // Acquisition: one tag must not lock; the second tag at spacing P locks.
    for (int k = 0; k < P; k++) step(1, 0);
    check(am_lock == '0, "R3 single tag no lock", 66'(am_lock), 66'(0));
    step(1, 0);
    check(am_lock == '1, "R3 lock after two tags", 66'(am_lock), 66'hF);
    check(aligned == 1, "R6 aligned", 66'(aligned), 66'(1));
    check(full_lock == '1, "R5 full_lock", 66'(full_lock), 66'hF);
    for (int p = 0; p < NL; p++)
      check(lane_map[p*2 +: 2] == 2'(perm[p]), "R5 R2 lane_map",
            66'(lane_map[p*2 +: 2]), 66'(perm[p]));

    // Forwarding with random idle gaps.
    for (int k = 0; k < 4 * P; k++) step(1, 1);

    // Loss hysteresis on lane 0.
    bad[0] = 1;
    repeat (3) to_slot();
    check(am_lock[0] == 1, "R4 three misses keep lock", 66'(am_lock[0]), 66'(1));
    bad[0] = 0;
    to_slot();
    bad[0] = 1;
    repeat (3) to_slot();
    check(am_lock[0] == 1, "R4 good tag resets count", 66'(am_lock[0]), 66'(1));
    to_slot();
    check(am_lock[0] == 0 && aligned == 0, "R4 fourth miss unlocks",
          66'({am_lock[0], aligned}), 66'(0));
    step(0, 0);
    check(am_lock == '0, "R7 flush all lanes", 66'(am_lock), 66'(0));
    bad[0] = 0;
    repeat (2) to_slot();
    check(aligned == 1, "R7 reacquire", 66'(aligned), 66'(1));

    // Wrong lane number on a locked lane counts as a failure.
    idf[1] = (perm[1] + 1) % NL;
    repeat (3) to_slot();
    check(am_lock[1] == 1, "R4 three mismatches keep lock", 66'(am_lock[1]), 66'(1));
    to_slot();
    check(am_lock[1] == 0, "R4 fourth mismatch unlocks", 66'(am_lock[1]), 66'(0));

    // Word lock loss on lane 2.
    do_reset();
    shuffle();
    for (int k = 0; k <= P; k++) step(0, 0);
    check(aligned == 1, "R6 aligned before wlock drop", 66'(aligned), 66'(1));
    @(negedge clk);
    in_wlock[2] = 1'b0;
    in_valid = '0;
    @(posedge clk); #1;
    check(am_lock[2] == 0 && full_lock[2] == 0 && aligned == 0, "R5 wlock drop",
          66'({am_lock[2], full_lock[2], aligned}), 66'(0));
    @(negedge clk);
    in_wlock = '1;

    // Fresh random permutations, checked from reset with gaps.
    for (int r = 0; r < 3; r++) begin
      do_reset();
      shuffle();
      for (int k = 0; k < 6 * P; k++) step(1, 1);
      check(aligned == 1, "R6 aligned random perm", 66'(aligned), 66'(1));
    end

    // Duplicate lane numbers never align and keep being flushed.
    do_reset();
    shuffle();
    idf[1] = perm[0];
    for (int k = 0; k < 5 * P; k++) step(0, 0);
    check(ever_al == 0, "R6 duplicate never aligned", 66'(ever_al), 66'(0));
    check(am_lock == '0, "R7 duplicate flushed", 66'(am_lock), 66'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule